// File: doc/BRIEF.md
# Transaction-framed CRC-16 generator

This block produces the 16-bit check value that goes with each transfer of a single-wire memory device. A byte-wide port accepts one byte per strobe. A small state machine knows which transfer is under way and which bytes it covers. A first read pass covers the command byte, the two address bytes and everything after them. A later read pass restarts the check on the page data alone. A scratchpad write covers the command, both target-address bytes and every data byte. At the end of a pass the block decides whether the check value goes out. After a read pass it always does. After a write it does only if one of the data bytes landed on the last scratchpad offset.

The value leaves the block bit-inverted, as two bytes with the low byte first. It uses a valid/ready handshake on a byte output. Each input byte is folded least significant bit first into a reflected register. The register's taps are 0xA001, which is the reflected form of x^16 + x^15 + x^2 + 1. A clear loads zero. The raw, uninverted register is also brought out so that it can be observed.

States: `ST_IDLE` (nothing is fed), `ST_RD_HEAD` and `ST_WR_HEAD` (the header bytes of a first read pass or of a write), `ST_RD_BODY` and `ST_WR_BODY` (the data bytes), `ST_SEND_LO` and `ST_SEND_HI` (the two output bytes). Transitions:
- Any state goes to a head state on `txn_start`, and to `ST_RD_BODY` on `pass_start`.
- A head state goes to its body state after the third header byte.
- A read state goes to `ST_SEND_LO` on `pass_end`.
- A write state goes to `ST_SEND_LO` on `pass_end` if the end-offset flag is set, and otherwise to `ST_IDLE`.
- `ST_SEND_LO` goes to `ST_SEND_HI`, and `ST_SEND_HI` goes to `ST_IDLE`, each on `out_ready`.

Top module: `crc16_frame_gen`

## Requirements
- R1: Each byte that is accepted updates the register one bit at a time, bit 0 first. For each bit, fb = crc[0] ^ bit; the register shifts right by one; if fb is 1 it is then XORed with 0xA001. Clearing loads 0x0000. `crc_now` shows the new value in the cycle after the strobe. The string "123456789" gives 0xBB3D.
- R2: At the end of a pass that sends, `out_valid` rises in the cycle after `pass_end`. `out_byte` first shows ~crc[7:0] and then ~crc[15:8]. Each byte is held stable while `out_ready` is low and moves on when `out_ready` is high at a clock edge. After the high byte, `out_valid` falls.
- R3: `txn_start` with `txn_write`=0 clears the register and starts a first read pass. The command byte, both address bytes and all the following bytes are covered. `pass_end` always leads to a send.
- R4: `pass_start` clears the register and starts a later read pass. Only the bytes that follow it are covered. `pass_end` always leads to a send.
- R5: `txn_start` with `txn_write`=1 starts a write. The register is cleared and covers the command, TA1, TA2 and the data bytes. The offset starts at TA1[4:0] (the second byte) and rises by one for each data byte, wrapping after 31.
- R6: A write sends its check value only if some data byte was written at offset 31. Otherwise `pass_end` returns the block to idle with `out_valid` left low.
- R7: Bytes that arrive while idle or while sending do not change the register. They also do not change `out_byte`.
- R8: `txn_start` or `pass_start` in any state abandons the current pass. It clears the register and the end-offset flag.
- R9: After reset, `out_valid` is 0 and `crc_now` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Begin a first read pass or a write; clears the register |
| txn_write | input | 1 | Kind of transfer with txn_start: 1 = write, 0 = read |
| pass_start | input | 1 | Begin a later read pass; clears the register |
| pass_end | input | 1 | Last byte of the pass has been given |
| byte_valid | input | 1 | Strobe for byte_in |
| byte_in | input | 8 | Byte to fold into the check value |
| out_ready | input | 1 | Consumer accepts out_byte |
| out_valid | output | 1 | out_byte holds a check byte to send |
| out_byte | output | 8 | Inverted check value, low byte first |
| crc_now | output | 16 | Raw register contents |

## Verification
All of the block's results come from a register or the state register, so each one is due exactly one clock edge after the stimulus that causes it. The bench drives inputs on the falling edge and samples on the next falling edge:
- `crc_now` after each byte strobe;
- `out_valid` and the low byte after `pass_end`;
- the high byte, and then the drop of `out_valid`, one edge after each accepted handshake.

Under back-pressure the bench samples across several falling edges to show the byte does not move. For a write that misses offset 31, it watches the idle cycles that follow to show that no send begins.

// File: rtl/crc16_frame_pkg.sv
package crc16_frame_pkg;

    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HEAD,
        ST_RD_BODY,
        ST_WR_HEAD,
        ST_WR_BODY,
        ST_SEND_LO,
        ST_SEND_HI
    } frame_state_t;

    // Fold one byte into a reflected CRC register, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold_byte(
        input logic [CRC_W-1:0]  cur,
        input logic [BYTE_W-1:0] din,
        input logic [CRC_W-1:0]  taps
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = cur;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ din[i];
            c  = c >> 1;
            if (fb) c = c ^ taps;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
    import crc16_frame_pkg::*;
#(
    parameter logic [CRC_W-1:0] TAPS      = 16'hA001,
    parameter logic [CRC_W-1:0] CLEAR_VAL = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              feed,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CLEAR_VAL;
        else if (clr)  crc <= CLEAR_VAL;
        else if (feed) crc <= crc_fold_byte(crc, din, TAPS);
    end

    // R7: with nothing fed and no clear, the register holds its value
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !feed) |=> $stable(crc));

    // R8: a clear always leaves the clear value behind
    a_r8_clear_loads_init: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == CLEAR_VAL));

endmodule

// File: rtl/wr_offset_tracker.sv
module wr_offset_tracker #(
    parameter int OFFSET_W   = 5,
    parameter int END_OFFSET = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic [OFFSET_W-1:0] load_val,
    input  logic                step,
    output logic                end_seen
);

    localparam logic [OFFSET_W-1:0] LAST_OFS = OFFSET_W'(END_OFFSET);

    logic [OFFSET_W-1:0] offset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset   <= '0;
            end_seen <= 1'b0;
        end else if (clr) begin
            offset   <= '0;
            end_seen <= 1'b0;
        end else if (load) begin
            offset   <= load_val;
        end else if (step) begin
            offset <= offset + 1'b1;
            if (offset == LAST_OFS) end_seen <= 1'b1;
        end
    end

    // R6: once the last offset has been written, the flag stays until a clear
    a_r6_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (end_seen && !clr) |=> end_seen);

    // R5: each data byte advances the offset by one
    a_r5_offset_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !clr) |=> (offset == $past(offset) + 1'b1));

endmodule

// File: rtl/crc16_frame_ctrl.sv
module crc16_frame_ctrl
    import crc16_frame_pkg::*;
#(
    parameter int HEAD_BYTES = 3,
    parameter int TA1_INDEX  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txn_start,
    input  logic txn_write,
    input  logic pass_start,
    input  logic pass_end,
    input  logic byte_valid,
    input  logic out_ready,
    input  logic end_seen,
    output logic crc_clr,
    output logic crc_feed,
    output logic trk_clr,
    output logic trk_load,
    output logic trk_step,
    output logic out_valid,
    output logic send_hi
);

    localparam int HCW = $clog2(HEAD_BYTES + 1);
    localparam logic [HCW-1:0] HEAD_LAST = HCW'(HEAD_BYTES - 1);
    localparam logic [HCW-1:0] TA1_POS   = HCW'(TA1_INDEX);

    frame_state_t   state, nstate;
    logic [HCW-1:0] hdr_cnt, nhdr;
    logic           any_start;
    logic           in_frame;

    assign any_start = txn_start | pass_start;
    assign in_frame  = (state == ST_RD_HEAD) || (state == ST_RD_BODY) ||
                       (state == ST_WR_HEAD) || (state == ST_WR_BODY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hdr_cnt <= '0;
        end else begin
            state   <= nstate;
            hdr_cnt <= nhdr;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        nhdr   = hdr_cnt;
        if (txn_start) begin
            nstate = txn_write ? ST_WR_HEAD : ST_RD_HEAD;
            nhdr   = '0;
        end else if (pass_start) begin
            nstate = ST_RD_BODY;
            nhdr   = '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RD_HEAD: begin
                    if (pass_end) nstate = ST_SEND_LO;
                    else if (byte_valid) begin
                        if (hdr_cnt == HEAD_LAST) begin
                            nstate = ST_RD_BODY;
                            nhdr   = '0;
                        end else begin
                            nhdr = hdr_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_BODY: begin
                    if (pass_end) nstate = ST_SEND_LO;
                end
                ST_WR_HEAD: begin
                    if (pass_end) nstate = end_seen ? ST_SEND_LO : ST_IDLE;
                    else if (byte_valid) begin
                        if (hdr_cnt == HEAD_LAST) begin
                            nstate = ST_WR_BODY;
                            nhdr   = '0;
                        end else begin
                            nhdr = hdr_cnt + 1'b1;
                        end
                    end
                end
                ST_WR_BODY: begin
                    if (pass_end) nstate = end_seen ? ST_SEND_LO : ST_IDLE;
                end
                ST_SEND_LO: begin
                    if (out_ready) nstate = ST_SEND_HI;
                end
                ST_SEND_HI: begin
                    if (out_ready) nstate = ST_IDLE;
                end
                default: nstate = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        crc_clr   = any_start;
        trk_clr   = any_start;
        crc_feed  = !any_start && !pass_end && byte_valid && in_frame;
        trk_load  = crc_feed && (state == ST_WR_HEAD) && (hdr_cnt == TA1_POS);
        trk_step  = crc_feed && (state == ST_WR_BODY);
        out_valid = (state == ST_SEND_LO) || (state == ST_SEND_HI);
        send_hi   = (state == ST_SEND_HI);
    end

    // R2: the low byte, once accepted, is followed by the high byte
    a_r2_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEND_LO) && out_ready && !any_start) |=> (state == ST_SEND_HI));

    // R6: a write that never reached the last offset does not send
    a_r6_no_send_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_WR_HEAD) || (state == ST_WR_BODY)) && pass_end && !end_seen && !any_start)
        |=> !out_valid);

    // R3: a read pass always ends in a send
    a_r3_read_sends: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_RD_HEAD) || (state == ST_RD_BODY)) && pass_end && !any_start)
        |=> (state == ST_SEND_LO));

endmodule

// File: rtl/crc16_frame_gen.sv
module crc16_frame_gen
    import crc16_frame_pkg::*;
#(
    parameter logic [CRC_W-1:0] TAPS       = 16'hA001,
    parameter logic [CRC_W-1:0] CLEAR_VAL  = 16'h0000,
    parameter int               HEAD_BYTES = 3,
    parameter int               OFFSET_W   = 5,
    parameter int               END_OFFSET = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_write,
    input  logic              pass_start,
    input  logic              pass_end,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic [CRC_W-1:0]  crc_now
);

    logic crc_clr, crc_feed, trk_clr, trk_load, trk_step, send_hi, end_seen;

    crc16_frame_ctrl #(
        .HEAD_BYTES (HEAD_BYTES),
        .TA1_INDEX  (1)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_write  (txn_write),
        .pass_start (pass_start),
        .pass_end   (pass_end),
        .byte_valid (byte_valid),
        .out_ready  (out_ready),
        .end_seen   (end_seen),
        .crc_clr    (crc_clr),
        .crc_feed   (crc_feed),
        .trk_clr    (trk_clr),
        .trk_load   (trk_load),
        .trk_step   (trk_step),
        .out_valid  (out_valid),
        .send_hi    (send_hi)
    );

    crc16_byte_engine #(
        .TAPS      (TAPS),
        .CLEAR_VAL (CLEAR_VAL)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .feed  (crc_feed),
        .din   (byte_in),
        .crc   (crc_now)
    );

    wr_offset_tracker #(
        .OFFSET_W   (OFFSET_W),
        .END_OFFSET (END_OFFSET)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trk_clr),
        .load     (trk_load),
        .load_val (byte_in[OFFSET_W-1:0]),
        .step     (trk_step),
        .end_seen (end_seen)
    );

    assign out_byte = send_hi ? ~crc_now[CRC_W-1:BYTE_W] : ~crc_now[BYTE_W-1:0];

    // R2: a byte offered but not taken stays put
    a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !txn_start && !pass_start)
        |=> (out_valid && $stable(out_byte)));

    // R7: while sending, the register does not move unless a new pass starts
    a_r7_frozen_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !txn_start && !pass_start) |=> $stable(crc_now));

endmodule

// File: tb/crc16_frame_gen_tb.sv
module crc16_frame_gen_tb;

    localparam time HALF = 2ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        txn_start, txn_write, pass_start, pass_end, byte_valid, out_ready;
    logic [7:0]  byte_in;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic [15:0] crc_now;

    int          n_run  = 0;
    int          n_fail = 0;
    logic [15:0] mdl;
    bit          finished = 1'b0;

    always #HALF clk = ~clk;

    crc16_frame_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_write  (txn_write),
        .pass_start (pass_start),
        .pass_end   (pass_end),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .crc_now    (crc_now)
    );

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return m_step_ret(r);
    endfunction

    function automatic logic [15:0] m_step_ret(input logic [15:0] v);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit counted);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        if (counted) mdl = m_step(mdl, b);
    endtask

    task automatic begin_txn(input bit wr);
        @(negedge clk);
        txn_start = 1'b1;
        txn_write = wr;
        @(negedge clk);
        txn_start = 1'b0;
        mdl = 16'h0000;
    endtask

    task automatic begin_next_pass();
        @(negedge clk);
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        mdl = 16'h0000;
    endtask

    // ends the pass; if a send is expected, collects both bytes and checks them
    task automatic end_pass(input bit expect_send, input string req);
        @(negedge clk);
        pass_end = 1'b1;
        @(negedge clk);
        pass_end = 1'b0;
        check(out_valid == expect_send, req, "out_valid after pass_end", out_valid, expect_send);
        if (expect_send) begin
            check(out_byte == ~mdl[7:0], req, "low byte", out_byte, ~mdl[7:0]);
            out_ready = 1'b1;
            @(negedge clk);
            check(out_valid && out_byte == ~mdl[15:8], req, "high byte", out_byte, ~mdl[15:8]);
            @(negedge clk);
            out_ready = 1'b0;
            check(!out_valid, "R2", "valid drops after high byte", out_valid, 0);
        end else begin
            repeat (3) @(negedge clk);
            check(!out_valid, req, "no send in idle cycles", out_valid, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; txn_start = 0; txn_write = 0; pass_start = 0; pass_end = 0;
        byte_valid = 0; byte_in = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
        check(crc_now == 16'h0000, "R9", "crc after reset", crc_now, 0);
    endtask

    // R1: known string "123456789" read as a first pass gives 0xBB3D
    task automatic t_known_vector();
        begin_txn(1'b0);
        for (int i = 0; i < 9; i++) push(8'h31 + 8'(i), 1'b1);
        check(crc_now == 16'hBB3D, "R1", "check string", crc_now, 16'hBB3D);
        check(mdl == 16'hBB3D, "R1", "model check string", mdl, 16'hBB3D);
        end_pass(1'b1, "R3");
    endtask

    // R3 then R4: first pass with header, then a later pass on data alone
    task automatic t_read_passes();
        begin_txn(1'b0);
        push(8'hF0, 1'b1); push(8'h40, 1'b1); push(8'h01, 1'b1);
        for (int i = 0; i < 6; i++) push(8'hA5 ^ 8'(i * 17), 1'b1);
        check(crc_now == mdl, "R3", "first pass crc", crc_now, mdl);
        end_pass(1'b1, "R3");
        begin_next_pass();
        check(crc_now == 16'h0000, "R4", "cleared by next pass", crc_now, 0);
        for (int i = 0; i < 5; i++) push(8'h3C + 8'(i), 1'b1);
        check(crc_now == mdl, "R4", "later pass crc", crc_now, mdl);
        end_pass(1'b1, "R4");
    endtask

    // R5, R6: start at offset 28, four data bytes reach 31
    task automatic t_write_hit();
        begin_txn(1'b1);
        push(8'h0F, 1'b1); push(8'hFC, 1'b1); push(8'h00, 1'b1);
        for (int i = 0; i < 4; i++) push(8'h11 * 8'(i + 1), 1'b1);
        check(crc_now == mdl, "R5", "write crc", crc_now, mdl);
        end_pass(1'b1, "R6");
    endtask

    // R6: offset 5, three bytes never reach 31
    task automatic t_write_miss();
        begin_txn(1'b1);
        push(8'h0F, 1'b1); push(8'h05, 1'b1); push(8'h00, 1'b1);
        for (int i = 0; i < 3; i++) push(8'h77, 1'b1);
        check(crc_now == mdl, "R5", "miss write crc", crc_now, mdl);
        end_pass(1'b0, "R6");
    endtask

    // R5, R6: offset from TA1 bits 4:0 only (0xFF -> 31), one byte hits
    task automatic t_write_at_last();
        begin_txn(1'b1);
        push(8'h0F, 1'b1); push(8'hFF, 1'b1); push(8'h01, 1'b1);
        push(8'h5A, 1'b1);
        end_pass(1'b1, "R6");
    endtask

    // R7: bytes in idle and while sending are ignored
    task automatic t_ignore();
        logic [15:0] held;
        logic [7:0]  ob;
        held = crc_now;
        push(8'h99, 1'b0); push(8'h12, 1'b0);
        check(crc_now == held, "R7", "idle bytes ignored", crc_now, held);
        check(!out_valid, "R7", "idle bytes start nothing", out_valid, 0);
        begin_txn(1'b0);
        push(8'hAA, 1'b1); push(8'h55, 1'b1); push(8'h01, 1'b1); push(8'h02, 1'b1);
        @(negedge clk); pass_end = 1'b1;
        @(negedge clk); pass_end = 1'b0;
        ob = out_byte;
        push(8'hEE, 1'b0);
        check(crc_now == mdl, "R7", "bytes during send ignored", crc_now, mdl);
        check(out_valid && out_byte == ob, "R7", "out_byte unchanged", out_byte, ob);
        // R2: back-pressure holds the low byte
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid && out_byte == ~mdl[7:0], "R2", "held under stall", out_byte, ~mdl[7:0]);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(out_valid && out_byte == ~mdl[15:8], "R2", "high byte held", out_byte, ~mdl[15:8]);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid, "R2", "done after high byte", out_valid, 0);
    endtask

    // R8: a restart mid-write clears the end flag and the register
    task automatic t_abort();
        begin_txn(1'b1);
        push(8'h0F, 1'b1); push(8'h1F, 1'b1); push(8'h00, 1'b1); push(8'h42, 1'b1);
        begin_txn(1'b1);
        check(crc_now == 16'h0000, "R8", "cleared by restart", crc_now, 0);
        push(8'h0F, 1'b1); push(8'h00, 1'b1); push(8'h00, 1'b1); push(8'h42, 1'b1);
        end_pass(1'b0, "R8");
        // restart during a send also abandons it
        begin_txn(1'b0);
        push(8'h01, 1'b1);
        @(negedge clk); pass_end = 1'b1;
        @(negedge clk); pass_end = 1'b0;
        begin_next_pass();
        check(!out_valid && crc_now == 16'h0000, "R8", "send abandoned", {out_valid, crc_now}, 0);
        push(8'h77, 1'b1);
        end_pass(1'b1, "R4");
    endtask

    initial begin
        t_reset();
        t_known_vector();
        t_read_passes();
        t_write_hit();
        t_write_miss();
        t_write_at_last();
        t_ignore();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule